// File: doc/BRIEF.md
# Fast Eight-Point Inverse DCT Butterfly

This block evaluates a one-dimensional eight-point inverse discrete cosine transform on signed 16-bit samples. It uses a scaled fast factorization with four fixed Q15 multipliers. Each multiplier is a doubling multiply-high that keeps the upper half of the product and saturates. Every other sum and difference wraps at 16 bits, so the outputs match a fixed 16-bit operation sequence bit for bit.

The block is a three-stage pipeline with no stalls. A vector presented with its valid flag is captured on a clock edge. Its eight results appear on the outputs three register stages later, together with an output valid flag. A new vector may enter on every clock. Dequantization, transposition between passes and final clamping belong to the surrounding logic.

Lanes are packed on both buses: lane i occupies bits [16i+15:16i] of `xIn` and of `yOut`.

Top module: `idct8_fast`

## Requirements
- R1: While reset is active and after it is released, `outValid` is 0 and `yOut` is all zero until the first result leaves the pipeline.
- R2: A vector captured with `inValid`=1 on edge n produces `outValid`=1 for exactly one cycle after edge n+2. `outValid` is never 1 otherwise.
- R3: A vector is accepted on every clock. Back-to-back vectors leave in the order they entered, one per clock, each with its own correct result.
- R4: The even lanes x0, x2, x4, x6 combine as follows:
  - a=x0+x4, b=x0-x4, g=x2+x6, h=x2-x6, k=M(h,13568)+h-g
  - E0=a+g, E3=a-g, E1=b+k, E2=b-k
  - With all odd inputs zero, the outputs are y0=y7=E0, y1=y6=E1, y2=y5=E2 and y3=y4=E3.
- R5: The odd lanes x1, x3, x5, x7 combine as follows:
  - p=x5+x3, q=x3-x5, r=x1+x7, u=x1-x7
  - O7=r+p, O11=M(r-p,13568)+(r-p)
  - s=u-q, f=M(s,27776)+s
  - O10=M(u,2688)+u-f, O12=M(q,20096)+q+q+f
  - O6=O12-O7, O5=O11-O6, O4=O10+O5
  - The outputs are y0=E0+O7, y7=E0-O7, y1=E1+O6, y6=E1-O6, y2=E2+O5, y5=E2-O5, y4=E3+O4 and y3=E3-O4.
- R6: Every addition and subtraction wraps modulo 2^16; for example 32767+1 gives -32768.
- R7: M(a,c) is floor(2*a*c / 2^16), clamped to [-32768, 32767]. The result rounds toward minus infinity, so M(-1000,13568) is -415.
- R8: A cycle with `inValid`=0 has no effect. The outputs keep their last value whenever `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Qualifies `xIn` for capture on this edge |
| xIn | input | 128 | Eight signed 16-bit input samples, lane i at bits [16i+15:16i] |
| outValid | output | 1 | `yOut` carries a new result this cycle |
| yOut | output | 128 | Eight signed 16-bit results, lane i at bits [16i+15:16i] |

## Verification
Capture of a new vector and release of an older result fall in the same cycle whenever the pipeline streams. The bench provokes this by driving long back-to-back runs and runs broken by single bubbles. Each result is judged against its own expected vector, popped in order and due exactly three edges after its capture. In the same run, the cycles with `inValid` low are checked for a flat `outValid` and unchanged `yOut`.

// File: rtl/idct8_pkg.sv
package idct8_pkg;
  localparam int W     = 16;
  localparam int LANES = 8;
  localparam int LAT   = 3;
  localparam int BUSW  = W * LANES;

  localparam logic signed [W-1:0] K0 = 16'sd2688;
  localparam logic signed [W-1:0] K1 = 16'sd13568;
  localparam logic signed [W-1:0] K2 = 16'sd27776;
  localparam logic signed [W-1:0] K3 = 16'sd20096;

  typedef logic signed [W-1:0] samp_t;

  // per-stage load strobes from control to datapath
  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
  } idctStb_t;

  // saturating doubling multiply-high: floor(2*a*c / 2^W)
  function automatic samp_t qmulh(input samp_t a, input samp_t c);
    logic signed [2*W-1:0] prod;
    logic signed [2*W-1:0] sh;
    prod = a * c;
    sh   = prod >>> (W - 1);
    if (sh > 32'sd32767)       qmulh = 16'sh7fff;
    else if (sh < -32'sd32768) qmulh = 16'sh8000;
    else                       qmulh = sh[W-1:0];
  endfunction
endpackage

// File: rtl/idct8_ctrl.sv
module idct8_ctrl
  import idct8_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output idctStb_t stb,
  output logic     outValid
);
  logic [LAT-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[LAT-2:0], inValid};
  end

  always_comb begin
    stb.ld1 = inValid;
    stb.ld2 = vPipe[0];
    stb.ld3 = vPipe[1];
  end
  assign outValid = vPipe[LAT-1];

  AST_LAT_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##3 outValid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 3)); // R2
endmodule

// File: rtl/idct8_dp.sv
module idct8_dp
  import idct8_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  idctStb_t        stb,
  input  logic [BUSW-1:0] xIn,
  output logic [BUSW-1:0] yOut
);
  samp_t xv [LANES];
  samp_t yReg [LANES];

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      assign xv[gi] = xIn[gi*W +: W];
      assign yOut[gi*W +: W] = yReg[gi];
    end
  endgenerate

  // stage 1: first butterflies
  samp_t sT10, sT11, sT13, sD, sZ13, sN10, sZ11, sZ12;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      {sT10, sT11, sT13, sD} <= '0;
      {sZ13, sN10, sZ11, sZ12} <= '0;
    end else if (stb.ld1) begin
      sT10 <= xv[0] + xv[4];
      sT11 <= xv[0] - xv[4];
      sT13 <= xv[2] + xv[6];
      sD   <= xv[2] - xv[6];
      sZ13 <= xv[5] + xv[3];
      sN10 <= xv[3] - xv[5];
      sZ11 <= xv[1] + xv[7];
      sZ12 <= xv[1] - xv[7];
    end
  end

  // stage 2: even and odd results
  samp_t cT12, cE0, cE1, cE2, cE3;
  samp_t cDiff, cO7, cO11, cS, cZ5, cO10, cO12, cO6, cO5, cO4;
  always_comb begin
    cT12  = qmulh(sD, K1) + sD - sT13;
    cE0   = sT10 + sT13;
    cE3   = sT10 - sT13;
    cE1   = sT11 + cT12;
    cE2   = sT11 - cT12;
    cO7   = sZ11 + sZ13;
    cDiff = sZ11 - sZ13;
    cO11  = qmulh(cDiff, K1) + cDiff;
    cS    = sZ12 - sN10;
    cZ5   = qmulh(cS, K2) + cS;
    cO10  = qmulh(sZ12, K0) + sZ12 - cZ5;
    cO12  = qmulh(sN10, K3) + (sN10 + sN10) + cZ5;
    cO6   = cO12 - cO7;
    cO5   = cO11 - cO6;
    cO4   = cO10 + cO5;
  end

  samp_t ev [4];
  samp_t od [4];
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin
        ev[i] <= '0;
        od[i] <= '0;
      end
    end else if (stb.ld2) begin
      ev[0] <= cE0; ev[1] <= cE1; ev[2] <= cE2; ev[3] <= cE3;
      od[0] <= cO7; od[1] <= cO6; od[2] <= cO5; od[3] <= cO4;
    end
  end

  // stage 3: output butterflies; lane k and 7-k pair up, except 3/4 swapped
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LANES; i++) yReg[i] <= '0;
    end else if (stb.ld3) begin
      yReg[0] <= ev[0] + od[0];
      yReg[7] <= ev[0] - od[0];
      yReg[1] <= ev[1] + od[1];
      yReg[6] <= ev[1] - od[1];
      yReg[2] <= ev[2] + od[2];
      yReg[5] <= ev[2] - od[2];
      yReg[4] <= ev[3] + od[3];
      yReg[3] <= ev[3] - od[3];
    end
  end

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ld3 |=> $stable(yOut)); // R8
  AST_ODD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ld1 && xv[1] == 0 && xv[3] == 0 && xv[5] == 0 && xv[7] == 0)
    |=> (sZ11 == 0 && sZ12 == 0 && sZ13 == 0 && sN10 == 0)); // R5
endmodule

// File: rtl/idct8_fast.sv
module idct8_fast
  import idct8_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [BUSW-1:0] xIn,
  output logic            outValid,
  output logic [BUSW-1:0] yOut
);
  idctStb_t stb;

  idct8_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .stb(stb), .outValid(outValid)
  );

  idct8_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .xIn(xIn), .yOut(yOut)
  );
endmodule

// File: tb/sim_idct8_fast.sv
module sim_idct8_fast;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [127:0] xIn = '0;
  logic outValid;
  logic [127:0] yOut;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  idct8_fast u0 (.clk(clk), .rstN(rstN), .inValid(inValid), .xIn(xIn),
                 .outValid(outValid), .yOut(yOut));

  typedef struct {
    int due;
    logic [127:0] y;
    string req;
  } exp_t;
  exp_t expQ[$];
  logic [127:0] lastY = '0;

  function automatic shortint mRef(shortint a, int c);
    longint p;
    p = (2 * longint'(a) * c) >>> 16;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return shortint'(p);
  endfunction

  function automatic logic [127:0] model(logic [127:0] x);
    shortint v[8];
    shortint t10, t11, t13, d, t12, e0, e1, e2, e3;
    shortint z13, n10, z11, z12, o7, df, o11, s, z5, o10, o12, o6, o5, o4;
    shortint y[8];
    logic [127:0] r;
    for (int i = 0; i < 8; i++) v[i] = shortint'(x[i*16 +: 16]);
    t10 = v[0] + v[4]; t11 = v[0] - v[4]; t13 = v[2] + v[6]; d = v[2] - v[6];
    t12 = mRef(d, 13568) + d - t13;
    e0 = t10 + t13; e3 = t10 - t13; e1 = t11 + t12; e2 = t11 - t12;
    z13 = v[5] + v[3]; n10 = v[3] - v[5]; z11 = v[1] + v[7]; z12 = v[1] - v[7];
    o7 = z11 + z13; df = z11 - z13; o11 = mRef(df, 13568) + df;
    s = z12 - n10; z5 = mRef(s, 27776) + s;
    o10 = mRef(z12, 2688) + z12 - z5;
    o12 = mRef(n10, 20096) + n10 + n10 + z5;
    o6 = o12 - o7; o5 = o11 - o6; o4 = o10 + o5;
    y[0] = e0 + o7; y[7] = e0 - o7; y[1] = e1 + o6; y[6] = e1 - o6;
    y[2] = e2 + o5; y[5] = e2 - o5; y[4] = e3 + o4; y[3] = e3 - o4;
    for (int i = 0; i < 8; i++) r[i*16 +: 16] = y[i];
    return r;
  endfunction

  function automatic logic [127:0] pack8(int a0, int a1, int a2, int a3,
                                          int a4, int a5, int a6, int a7);
    return {a7[15:0], a6[15:0], a5[15:0], a4[15:0],
            a3[15:0], a2[15:0], a1[15:0], a0[15:0]};
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // output monitor: due time, order, value and hold behaviour
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (expQ.size() > 0 && expQ[0].due == cyc) begin
        check({expQ[0].req, "/R2 valid"}, {127'd0, outValid}, 128'd1);
        check(expQ[0].req, yOut, expQ[0].y);
        void'(expQ.pop_front());
        lastY = yOut;
      end else begin
        check("R2 no valid", {127'd0, outValid}, 128'd0);
        check("R8 hold", yOut, lastY);
      end
    end
  end

  // vector presented now is captured at next edge and due 3 edges later
  task automatic sendVec(logic [127:0] x, logic [127:0] exp, string req);
    @(negedge clk);
    inValid = 1'b1;
    xIn = x;
    expQ.push_back('{due: cyc + 3, y: exp, req: req});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      xIn = {$urandom, $urandom, $urandom, $urandom};
    end
  endtask

  task automatic drain();
    idle(5);
  endtask

  task automatic testReset();
    check("R1 outValid", {127'd0, outValid}, 128'd0);
    check("R1 yOut", yOut, 128'd0);
  endtask

  task automatic testEven();
    sendVec(pack8(100, 0, 0, 0, 0, 0, 0, 0), pack8(100, 100, 100, 100, 100, 100, 100, 100), "R4 dc");
    sendVec(pack8(0, 0, 1000, 0, 0, 0, 0, 0),
            pack8(1000, 414, -414, -1000, -1000, -414, 414, 1000), "R4 x2");
    idle(1);
    drain();
  endtask

  task automatic testOdd();
    sendVec(pack8(0, 1000, 0, 0, 0, 0, 0, 0),
            pack8(1000, 847, 567, 198, -198, -567, -847, -1000), "R5 x1");
    drain();
  endtask

  task automatic testWrap();
    sendVec(pack8(32767, 0, 0, 0, 1, 0, 0, 0),
            pack8(-32768, 32766, 32766, -32768, -32768, 32766, 32766, -32768), "R6 wrap");
    drain();
  endtask

  task automatic testFloor();
    sendVec(pack8(0, 0, -1000, 0, 0, 0, 0, 0),
            pack8(-1000, -415, 415, 1000, 1000, 415, -415, -1000), "R7 floor");
    drain();
  endtask

  task automatic testSat();
    logic [127:0] x;
    x = pack8(-32768, -32768, -32768, 32767, 0, 32767, -32768, 32767);
    sendVec(x, model(x), "R7 extreme");
    drain();
  endtask

  task automatic testStream();
    logic [127:0] x;
    for (int i = 0; i < 20; i++) begin
      x = {$urandom, $urandom, $urandom, $urandom};
      sendVec(x, model(x), "R3 stream");
    end
    drain();
  endtask

  task automatic testBubbles();
    logic [127:0] x;
    for (int i = 0; i < 30; i++) begin
      for (int k = 0; k < 8; k++) x[k*16 +: 16] = 16'($signed($urandom_range(0, 2000)) - 1000);
      sendVec(x, model(x), "R5 mixed");
      if (i % 3 == 1) idle(1);
    end
    drain();
  endtask

  task automatic testIgnore();
    idle(6);
    check("R8 quiet", {127'd0, outValid}, 128'd0);
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEven();
    testOdd();
    testWrap();
    testFloor();
    testSat();
    testStream();
    testIgnore();
    testBubbles();
    check("R3 all drained", 128'(expQ.size()), 128'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule